// File: doc/BRIEF.md
# Write-Protect Unlock Sequence Detector

This block watches the stream of byte-write events that a page-load engine accepts. It looks for fixed address/data unlock patterns at the start of each load window and keeps a protect state that decides whether a load may put data into the array. Each accepted event gets one disposition for the page engine:
- a command byte, which is never stored;
- a byte to store;
- a dummy byte, for which the write timer runs but nothing is written.

A three-step key (0xAA at address A, 0x55 at address B, 0xA0 at address A, where A = 0x5555 and B = 0x2AAA by default) does two things. It arms protection, and it unlocks the rest of its own load. A six-step key (0xAA@A, 0x55@B, 0x80@A, 0xAA@A, 0x55@B, 0x20@A) drops protection and also unlocks its own load. A protect change is applied only when the programming cycle that follows the load finishes. This holds even when the load contains nothing but the key.

Write events come in on a valid/ready stream. `wr_ready` goes low in the cycle after the load window closes and stays low until the cycle after `prog_done`. The producer must hold an event while ready is low. The disposition output has no back-pressure: it is a single-cycle pulse. The protect register has its own reset, which stands in for a non-volatile bit.

Top module: `wp_seq_detect`

## Requirements
- R1: After reset, `protect_on` is 0, `wr_ready` is 1 and `disp_valid` is 0. Asserting `rst_n` low at any time returns `protect_on` to 0.
- R2: Every event accepted (`wr_valid && wr_ready` at a rising edge) gives exactly one `disp_valid` pulse in the next cycle. `disp_kind` encodes the result: 1 = command (do not store), 2 = store, 3 = dummy. No pulse appears without an accepted event.
- R3: The three-step key, matched from the first event of a load, is reported as three command dispositions. Every later event of that load is reported as store.
- R4: The six-step key, matched from the first event of a load, is reported as six command dispositions. Later events of the load are reported as store. `protect_on` becomes 0 when that load's programming cycle ends.
- R5: `protect_on` changes only in the cycle after `prog_done` is sampled high while a programming cycle is pending. The three-step key sets it to 1 even if the load has no data bytes.
- R6: While protected, every event of a load that does not begin with a key is reported as dummy.
- R7: While unprotected, a byte that breaks a partly matched key is reported as store. Its `disp_promote` gives the number of earlier key bytes of this load (1 to 5) that the page engine must now store as data. All later bytes of that load are reported as store.
- R8: While protected, a byte that breaks a partly matched key is reported as dummy, and so is every later byte of that load.
- R9: Keys are matched only from the first event of a load. Key bytes later in a load are reported as store when unprotected and as dummy when protected, and they do not change the protect state.
- R10: `window_expired` with an open load makes `wr_ready` 0 in the next cycle, and it stays 0 until the cycle after `prog_done`. `window_expired` with no open load, and `prog_done` with no pending cycle, have no effect.
- R11: A load window that closes with a key only partly matched promotes nothing and leaves the protect state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, including the protect bit |
| wr_valid | input | 1 | A write event is offered |
| wr_ready | output | 1 | Event can be accepted (low while programming is pending) |
| wr_addr | input | ADDR_W (15) | Event address |
| wr_data | input | DATA_W (8) | Event data |
| window_expired | input | 1 | Byte-load window has closed |
| prog_done | input | 1 | Programming cycle finished |
| protect_on | output | 1 | Protect state |
| disp_valid | output | 1 | Disposition pulse |
| disp_kind | output | 2 | 1 command, 2 store, 3 dummy |
| disp_promote | output | 3 | Count of earlier key bytes to store as data |

## Verification
A disposition is due one cycle after the edge that accepts its event. The bench drives each event on a falling edge and reads `disp_valid`, `disp_kind` and `disp_promote` on the next falling edge. `wr_ready` is read one falling edge after `window_expired` is driven, and again after `prog_done`. `protect_on` is checked while the programming cycle is still pending, to show it has not moved, and again one falling edge after `prog_done`, when the new value is due. Expected values come from a bench model that applies the requirements event by event, to both directed key patterns and seeded random loads.

// File: rtl/wpsd_pkg.sv
package wpsd_pkg;
  typedef enum logic [1:0] {
    DISP_NONE  = 2'd0,
    DISP_CMD   = 2'd1,
    DISP_STORE = 2'd2,
    DISP_DUMMY = 2'd3
  } disp_e;

  typedef enum logic [1:0] {
    MODE_SEEK  = 2'd0,
    MODE_STORE = 2'd1,
    MODE_DUMMY = 2'd2
  } mode_e;

  localparam int KEY_LONG  = 6;
  localparam int STEP_W    = $clog2(KEY_LONG);
  localparam int ARM_STEP  = 2;
  localparam logic [7:0] ARM_BYTE = 8'hA0;

  // address select for each step of the long key: 0 picks address A, 1 picks B
  function automatic logic key_sel(input logic [STEP_W-1:0] idx);
    return (idx == 3'd1) || (idx == 3'd4);
  endfunction

  function automatic logic [7:0] key_byte(input logic [STEP_W-1:0] idx);
    case (idx)
      3'd0, 3'd3: return 8'hAA;
      3'd1, 3'd4: return 8'h55;
      3'd2:       return 8'h80;
      default:    return 8'h20;
    endcase
  endfunction
endpackage

// File: rtl/wpsd_cycle_ctl.sv
module wpsd_cycle_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_fire,
  input  logic window_expired,
  input  logic prog_done,
  output logic busy,
  output logic load_end,
  output logic commit
);
  logic load_open;

  assign load_end = window_expired && (load_open || ev_fire) && !busy;
  assign commit   = busy && prog_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      load_open <= 1'b0;
    end else begin
      if (load_end) begin
        busy      <= 1'b1;
        load_open <= 1'b0;
      end else if (ev_fire) begin
        load_open <= 1'b1;
      end
      if (commit) busy <= 1'b0;
    end
  end

  assert_busy_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_end |=> busy);
  assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_done) |=> busy);
  assert_idle_on_stray_expiry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load_open && !ev_fire) |=> !busy);
endmodule

// File: rtl/wpsd_matcher.sv
module wpsd_matcher
  import wpsd_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 15'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 15'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_fire,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DATA_W-1:0] ev_data,
  input  logic              protect,
  input  logic              load_end,
  input  logic              commit,
  output disp_e             ev_kind,
  output logic [STEP_W-1:0] ev_promote,
  output logic              pend_set,
  output logic              pend_clr
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(KEY_LONG - 1);

  mode_e             mode, mode_nx;
  logic [STEP_W-1:0] step, step_nx;
  logic              set_now, clr_now;
  logic              step_hit, arm_hit;
  logic [ADDR_W-1:0] want_addr;

  assign want_addr = key_sel(step) ? KEY_ADDR_B : KEY_ADDR_A;
  assign step_hit  = (ev_addr == want_addr) && (ev_data == DATA_W'(key_byte(step)));
  assign arm_hit   = (step == STEP_W'(ARM_STEP)) && (ev_addr == KEY_ADDR_A)
                     && (ev_data == DATA_W'(ARM_BYTE));

  always_comb begin
    ev_kind    = DISP_NONE;
    ev_promote = '0;
    mode_nx    = mode;
    step_nx    = step;
    set_now    = 1'b0;
    clr_now    = 1'b0;
    if (ev_fire) begin
      unique case (mode)
        MODE_SEEK: begin
          if (arm_hit) begin
            ev_kind = DISP_CMD;
            set_now = 1'b1;
            mode_nx = MODE_STORE;
            step_nx = '0;
          end else if (step_hit) begin
            ev_kind = DISP_CMD;
            if (step == LAST_STEP) begin
              clr_now = 1'b1;
              mode_nx = MODE_STORE;
              step_nx = '0;
            end else begin
              step_nx = step + 1'b1;
            end
          end else if (protect) begin
            ev_kind = DISP_DUMMY;
            mode_nx = MODE_DUMMY;
            step_nx = '0;
          end else begin
            ev_kind    = DISP_STORE;
            ev_promote = step;
            mode_nx    = MODE_STORE;
            step_nx    = '0;
          end
        end
        MODE_STORE: ev_kind = DISP_STORE;
        default:    ev_kind = DISP_DUMMY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_SEEK;
      step <= '0;
    end else if (load_end) begin
      mode <= MODE_SEEK;
      step <= '0;
    end else begin
      mode <= mode_nx;
      step <= step_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_set <= 1'b0;
      pend_clr <= 1'b0;
    end else if (commit) begin
      pend_set <= 1'b0;
      pend_clr <= 1'b0;
    end else if (set_now) begin
      pend_set <= 1'b1;
      pend_clr <= 1'b0;
    end else if (clr_now) begin
      pend_set <= 1'b0;
      pend_clr <= 1'b1;
    end
  end

  assert_dummy_only_protected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && mode == MODE_DUMMY) |-> protect);
  assert_store_mode_no_promote_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_SEEK) |-> (ev_promote == '0));
  assert_seek_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_end |=> (mode == MODE_SEEK && step == '0));
endmodule

// File: rtl/wpsd_protect_reg.sv
module wpsd_protect_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic pend_set,
  input  logic pend_clr,
  output logic protect
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   protect <= 1'b0;
    else if (commit && pend_set)  protect <= 1'b1;
    else if (commit && pend_clr)  protect <= 1'b0;
  end

  assert_change_on_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(protect) |-> $past(commit));
endmodule

// File: rtl/wp_seq_detect.sv
module wp_seq_detect
  import wpsd_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 15'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 15'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              window_expired,
  input  logic              prog_done,
  output logic              protect_on,
  output logic              disp_valid,
  output logic [1:0]        disp_kind,
  output logic [2:0]        disp_promote
);
  logic              busy, load_end, commit, ev_fire;
  logic              pend_set, pend_clr;
  disp_e             ev_kind;
  logic [STEP_W-1:0] ev_promote;

  assign wr_ready = !busy;
  assign ev_fire  = wr_valid && wr_ready;

  wpsd_cycle_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .ev_fire(ev_fire), .window_expired(window_expired),
    .prog_done(prog_done), .busy(busy), .load_end(load_end), .commit(commit)
  );

  wpsd_matcher #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR_A(KEY_ADDR_A), .KEY_ADDR_B(KEY_ADDR_B)
  ) u_match (
    .clk(clk), .rst_n(rst_n), .ev_fire(ev_fire), .ev_addr(wr_addr), .ev_data(wr_data),
    .protect(protect_on), .load_end(load_end), .commit(commit), .ev_kind(ev_kind),
    .ev_promote(ev_promote), .pend_set(pend_set), .pend_clr(pend_clr)
  );

  wpsd_protect_reg u_prot (
    .clk(clk), .rst_n(rst_n), .commit(commit), .pend_set(pend_set),
    .pend_clr(pend_clr), .protect(protect_on)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_valid   <= 1'b0;
      disp_kind    <= 2'd0;
      disp_promote <= '0;
    end else begin
      disp_valid   <= ev_fire;
      disp_kind    <= ev_kind;
      disp_promote <= 3'(ev_promote);
    end
  end

  assert_disp_coded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_kind != 2'd0));
  assert_no_disp_when_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> !disp_valid);
  assert_dummy_needs_protect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_kind == 2'd3) |-> protect_on);
  assert_promote_unprotected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_promote != 3'd0) |-> (disp_valid && disp_kind == 2'd2 && !protect_on));
endmodule

// File: tb/wp_seq_detect_test.sv
module wp_seq_detect_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        window_expired = 1'b0;
  logic        prog_done = 1'b0;
  logic        protect_on, disp_valid;
  logic [1:0]  disp_kind;
  logic [2:0]  disp_promote;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 0;

  // bench model state
  bit m_prot, m_pset, m_pclr, m_open;
  int m_mode, m_k;

  localparam logic [14:0] KA = 15'h5555;
  localparam logic [14:0] KB = 15'h2AAA;

  always #2.5 clk = ~clk;

  wp_seq_detect uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .window_expired(window_expired),
    .prog_done(prog_done), .protect_on(protect_on), .disp_valid(disp_valid),
    .disp_kind(disp_kind), .disp_promote(disp_promote)
  );

  function automatic logic [14:0] k_addr(int i);
    return (i == 1 || i == 4) ? KB : KA;
  endfunction
  function automatic logic [7:0] k_data(int i);
    case (i)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      2:    return 8'h80;
      default: return 8'h20;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_prot = 0; m_pset = 0; m_pclr = 0; m_open = 0; m_mode = 0; m_k = 0;
  endtask

  task automatic model_event(input logic [14:0] a, input logic [7:0] d,
                             output int kind, output int prom);
    prom = 0;
    m_open = 1;
    if (m_mode == 0) begin
      if (m_k == 2 && a == KA && d == 8'hA0) begin
        kind = 1; m_pset = 1; m_pclr = 0; m_mode = 1; m_k = 0;
      end else if (a == k_addr(m_k) && d == k_data(m_k)) begin
        kind = 1;
        if (m_k == 5) begin m_pclr = 1; m_pset = 0; m_mode = 1; m_k = 0; end
        else m_k++;
      end else if (m_prot) begin
        kind = 3; m_mode = 2; m_k = 0;
      end else begin
        kind = 2; prom = m_k; m_mode = 1; m_k = 0;
      end
    end else kind = (m_mode == 1) ? 2 : 3;
  endtask

  // called right after a falling edge
  task automatic send(input logic [14:0] a, input logic [7:0] d, input string req);
    int ek, ep;
    wr_valid = 1; wr_addr = a; wr_data = d;
    model_event(a, d, ek, ep);
    @(negedge clk);
    wr_valid = 0;
    check({req, " disp_valid"}, disp_valid, 1);
    check({req, " disp_kind"}, disp_kind, ek);
    check({req, " disp_promote"}, disp_promote, ep);
  endtask

  task automatic send_arm(input string req);
    send(KA, 8'hAA, req); send(KB, 8'h55, req); send(KA, 8'hA0, req);
  endtask

  task automatic send_drop(input string req);
    for (int i = 0; i < 6; i++) send(k_addr(i), k_data(i), req);
  endtask

  task automatic close_load(input int hold);
    bit old = m_prot;
    window_expired = 1;
    @(negedge clk);
    window_expired = 0;
    check("R10 ready low after window", wr_ready, 0);
    m_open = 0; m_mode = 0; m_k = 0;
    // an offered event during programming must be ignored
    wr_valid = 1; wr_addr = KA; wr_data = 8'hAA;
    @(negedge clk);
    wr_valid = 0;
    check("R10 no disposition while busy", disp_valid, 0);
    for (int i = 0; i < hold; i++) @(negedge clk);
    check("R5 protect held until done", protect_on, old);
    prog_done = 1;
    @(negedge clk);
    prog_done = 0;
    if (m_pset) m_prot = 1;
    if (m_pclr) m_prot = 0;
    m_pset = 0; m_pclr = 0;
    check("R5 protect after done", protect_on, m_prot);
    check("R10 ready after done", wr_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset protect", protect_on, 0);
    check("R1 reset ready", wr_ready, 1);
    check("R1 reset disp_valid", disp_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 plain byte while unprotected
    send(15'h0123, 8'h3C, "R2 plain store");
    close_load(2);

    // R3 / R5: key alone arms protection at end of cycle
    send_arm("R3 arm key");
    close_load(4);
    check("R5 armed with no data", protect_on, 1);

    // R6: unprefixed writes while protected
    send(15'h0040, 8'h11, "R6 unprefixed");
    send(15'h0041, 8'h22, "R6 unprefixed");
    close_load(1);

    // R3: prefixed write while protected
    send_arm("R3 prefix");
    send(15'h0080, 8'h5A, "R3 data after key");
    send(15'h0081, 8'hA5, "R3 data after key");
    close_load(1);

    // R8: protected, key broken at step 1
    send(KA, 8'hAA, "R8 partial");
    send(KB, 8'h56, "R8 break");
    send(15'h0002, 8'h01, "R8 after break");
    close_load(1);

    // R9: key bytes later in a protected load
    send(15'h0100, 8'h77, "R9 lead byte");
    send_arm("R9 late key");
    close_load(1);
    check("R9 protect kept", protect_on, 1);

    // R10: stray expiry and stray done
    window_expired = 1;
    @(negedge clk);
    window_expired = 0;
    check("R10 stray expiry ignored", wr_ready, 1);
    prog_done = 1;
    @(negedge clk);
    prog_done = 0;
    check("R10 stray done ignored", protect_on, 1);

    // R11: partial key at window end while protected
    send(KA, 8'hAA, "R11 partial");
    send(KB, 8'h55, "R11 partial");
    close_load(1);
    check("R11 no change", protect_on, 1);

    // R4: disable key with a data byte
    send_drop("R4 drop key");
    send(15'h0200, 8'h99, "R4 data after key");
    close_load(2);
    check("R4 protect cleared", protect_on, 0);

    // R7: unprotected break after two key bytes
    send(KA, 8'hAA, "R7 partial");
    send(KB, 8'h55, "R7 partial");
    send(KA, 8'h81, "R7 break promote");
    send(15'h0003, 8'h04, "R7 after break");
    close_load(1);

    // R9 unprotected: late key is data
    send(15'h0300, 8'h10, "R9 lead byte");
    send_arm("R9 late key unprot");
    close_load(1);
    check("R9 stays unprotected", protect_on, 0);

    // R11 unprotected partial
    send(KA, 8'hAA, "R11 partial unprot");
    close_load(1);

    // seeded random loads
    for (int n = 0; n < 80; n++) begin
      int pick = $urandom % 5;
      int nd = $urandom % 4;
      int kk = ($urandom % 5) + 1;
      case (pick)
        0: ;
        1: send_arm("R3 random arm");
        2: send_drop("R4 random drop");
        3: begin
             for (int i = 0; i < kk; i++) send(k_addr(i), k_data(i), "R7 R8 random partial");
             send(15'h0000, 8'h00, "R7 R8 random break");
           end
        default: for (int i = 0; i < kk; i++) send(k_addr(i), k_data(i), "R11 random partial");
      endcase
      for (int i = 0; i < nd; i++)
        send(15'($urandom), 8'($urandom), "R2 random data");
      if (pick == 0 && nd == 0) send(15'h0011, 8'h22, "R2 random single");
      close_load($urandom % 3);
    end

    // R1: reset from the protected state
    if (!m_prot) begin
      send_arm("R1 arm before reset");
      close_load(1);
    end
    check("R1 protected before reset", protect_on, 1);
    rst_n = 0;
    @(negedge clk);
    model_reset();
    check("R1 protect cleared by reset", protect_on, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 ready after reset", wr_ready, 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule